// File: doc/BRIEF.md
# SPI Master with Chip-Select Timing Windows

This block sends and receives one data word per request over a four-wire serial link. Each word is framed by an active-low chip select. The block waits a programmed setup interval after chip select goes low before the first clock edge, and waits a programmed hold interval after the last data bit before chip select is released. It then inserts a programmed idle gap before it reports completion. A parity bit can follow each word.

Each chip select has its own settings, taken from flat configuration vectors. The settings are setup, hold and gap lengths, a timer bypass, parity enable and polarity, and two enable-response windows. The slave drives an active-low ready line. This line must go low soon enough after chip select asserts, and it must go high soon enough after the data ends. If the first window is missed, the word is aborted and an error is reported. If the second window is missed, an error is reported. A host may ask to keep chip select low between words to the same slave. The next word then skips the setup, hold and both window checks, but still waits out the gap.

Top module: `spi_cst_master`

## Requirements
- R1: While reset is low, and after it, all chip selects are high (deasserted), `sck` is low, `in_ready` is high and `out_done` is low.
- R2: Data moves MSB first in mode 0. `sck` idles low, is high for `sck_half` module clocks and low for `sck_half` module clocks per bit (a value of 0 acts as 1). `mosi` changes only while `sck` is low. `miso` is sampled on each rising edge. `out_data` holds the received data word when `out_done` pulses.
- R3: When `cfg_par_en[i]` is 1, one extra bit follows the data. If `cfg_par_even[i]` is 0 the bit gives an odd count of ones over data plus parity. If it is 1 the count is even. When `cfg_par_en[i]` is 0, no extra bit is sent.
- R4: The first rising `sck` edge comes setup+`sck_half` module clocks after the clock edge that registers chip select low. When `cfg_tmr_off[i]` is 1, the setup value counts as 0.
- R5: Chip select rises hold module clocks after the clock edge that ends the last bit. When `cfg_tmr_off[i]` is 1, the hold value counts as 0.
- R6: `out_done` pulses gap+1 module clocks after chip select rises. It is delayed further only while a ready window is still open. `in_ready` is high again from that cycle.
- R7: Let W = `cfg_en_on[i]`·2·`sck_half`. `slv_en_n` must be seen low within W module clocks of the accepting edge. If it is not, the word stops shifting. Chip select rises hold clocks after the abort edge, and `out_err` is 1 with `out_done`.
- R8: Let W = `cfg_en_off[i]`·2·`sck_half`. `slv_en_n` must be seen high within W module clocks of the last bit's edge. If it is not, `out_err` is 1 with `out_done`.
- R9: A word accepted with `in_hold_cs`=1 leaves chip select low through its gap and skips its hold and off-window check. The next word to the same chip select skips setup and the on-window check. Its first rising edge comes `sck_half` clocks after acceptance.
- R10: Only the chip select numbered `in_cs` goes low; at most one is ever low. Timing and parity come from that chip select's fields. Field i of each vector sits at bits [i·W +: W].
- R11: `out_done` is a one-cycle pulse. `out_err` rises only together with `out_done` and clears when the next word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_half | input | DIV_W | Half period of `sck` in module clocks |
| cfg_setup | input | NUM_CS·TMR_W | Per chip select setup length |
| cfg_hold | input | NUM_CS·TMR_W | Per chip select hold length |
| cfg_gap | input | NUM_CS·TMR_W | Per chip select idle gap length |
| cfg_en_on | input | NUM_CS·WIN_W | Ready-assert window, in `sck` periods |
| cfg_en_off | input | NUM_CS·WIN_W | Ready-release window, in `sck` periods |
| cfg_par_en | input | NUM_CS | Parity bit enable |
| cfg_par_even | input | NUM_CS | Parity polarity: 0 odd, 1 even |
| cfg_tmr_off | input | NUM_CS | Bypass setup and hold |
| in_valid | input | 1 | Word request |
| in_ready | output | 1 | Block can take a word |
| in_data | input | DATA_W | Word to transmit |
| in_cs | input | CS_W | Target chip select number |
| in_hold_cs | input | 1 | Keep chip select low after this word |
| out_done | output | 1 | One-cycle completion pulse |
| out_err | output | 1 | Window violation for the finished word |
| out_data | output | DATA_W | Received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |
| slv_en_n | input | 1 | Active-low slave ready |

## Verification
Every cycle, the assertions check the framing rules. At most one chip select may be low. `sck` must stay low while no chip select is low. `mosi` must hold still while `sck` is high. The done and error flags must have the right pulse shape, an expired window must close, and the clock phase counter must stay in range. The exact cycle counts of setup, bit timing, hold and gap can only be shown by the bench's sweeps. So can the parity value, the per-chip-select selection, the window pass/fail boundaries and the held chip select sequence. The bench measures each of these against arithmetic built from the programmed values.

// File: rtl/spi_cst_pkg.sv
// Shared types for the chip-select-timed SPI master.
package spi_cst_pkg;
    // Sequencer phases of one word transfer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } seq_state_t;
endpackage

// File: rtl/spi_cst_cfgsel.sv
// Per-chip-select configuration selector.
// Unpacks the flat per-chip-select vectors and presents the fields of the
// chip select named by sel. Assumes the fields are static during a word.
module spi_cst_cfgsel #(
    parameter int NUM_CS = 2,
    parameter int TMR_W  = 4,
    parameter int WIN_W  = 3,
    parameter int CS_W   = 1
) (
    input  logic [CS_W-1:0]         sel,
    input  logic [NUM_CS*TMR_W-1:0] cfg_setup,
    input  logic [NUM_CS*TMR_W-1:0] cfg_hold,
    input  logic [NUM_CS*TMR_W-1:0] cfg_gap,
    input  logic [NUM_CS*WIN_W-1:0] cfg_en_on,
    input  logic [NUM_CS*WIN_W-1:0] cfg_en_off,
    input  logic [NUM_CS-1:0]       cfg_par_en,
    input  logic [NUM_CS-1:0]       cfg_par_even,
    input  logic [NUM_CS-1:0]       cfg_tmr_off,
    output logic [TMR_W-1:0]        setup,
    output logic [TMR_W-1:0]        hold,
    output logic [TMR_W-1:0]        gap,
    output logic [WIN_W-1:0]        en_on,
    output logic [WIN_W-1:0]        en_off,
    output logic                    par_en,
    output logic                    par_even,
    output logic                    tmr_off
);
    logic [TMR_W-1:0] su_a [NUM_CS];
    logic [TMR_W-1:0] ho_a [NUM_CS];
    logic [TMR_W-1:0] gp_a [NUM_CS];
    logic [WIN_W-1:0] on_a [NUM_CS];
    logic [WIN_W-1:0] of_a [NUM_CS];

    // Slice each flat vector into one entry per chip select.
    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_unpack
            assign su_a[i] = cfg_setup[i*TMR_W +: TMR_W];
            assign ho_a[i] = cfg_hold[i*TMR_W +: TMR_W];
            assign gp_a[i] = cfg_gap[i*TMR_W +: TMR_W];
            assign on_a[i] = cfg_en_on[i*WIN_W +: WIN_W];
            assign of_a[i] = cfg_en_off[i*WIN_W +: WIN_W];
        end
    endgenerate

    // Pick the selected entry; out-of-range numbers read as all zero.
    always_comb begin
        setup = '0; hold = '0; gap = '0; en_on = '0; en_off = '0;
        par_en = 1'b0; par_even = 1'b0; tmr_off = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (int'(sel) == i) begin
                setup    = su_a[i];
                hold     = ho_a[i];
                gap      = gp_a[i];
                en_on    = on_a[i];
                en_off   = of_a[i];
                par_en   = cfg_par_en[i];
                par_even = cfg_par_even[i];
                tmr_off  = cfg_tmr_off[i];
            end
        end
    end
endmodule

// File: rtl/spi_cst_sckgen.sv
// Serial clock generator for mode 0.
// While run is high, sck toggles every half module clocks, starting low.
// rise/fall flag the clock edge at which sck goes high/low. sck is forced
// low as soon as run drops. Assumes half >= 1 and static while running.
module spi_cst_sckgen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] pc_q;
    logic             sck_q;
    logic [DIV_W-1:0] half_m1;
    logic             flip;

    assign half_m1 = half - DIV_W'(1);
    assign flip    = run && (pc_q == half_m1);

    // Phase counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pc_q  <= '0;
            sck_q <= 1'b0;
        end else if (flip) begin
            pc_q  <= '0;
            sck_q <= ~sck_q;
        end else begin
            pc_q  <= pc_q + DIV_W'(1);
        end
    end

    assign sck  = sck_q && run;
    assign rise = flip && !sck_q;
    assign fall = flip && sck_q;

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && $stable(half) |-> pc_q <= half_m1);
endmodule

// File: rtl/spi_cst_window.sv
// Response window timer.
// start loads a limit. From the next clock on, each cycle either sees the
// awaited level (window closes cleanly) or counts down. At zero without
// the level, expire pulses and the window closes. resolved is high when
// no window is pending after this cycle.
module spi_cst_window #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] limit,
    input  logic             level_ok,
    output logic             expire,
    output logic             resolved
);
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    // Window open/close and countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= limit;
        end else if (active_q) begin
            if (level_ok || cnt_q == '0) active_q <= 1'b0;
            else                         cnt_q    <= cnt_q - CNT_W'(1);
        end
    end

    assign expire   = active_q && !level_ok && (cnt_q == '0);
    assign resolved = !active_q || level_ok || (cnt_q == '0);

    assert_window_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active_q && !level_ok && cnt_q == '0 && !start |=> !active_q);
endmodule

// File: rtl/spi_cst_master.sv
// SPI master with per-chip-select setup/hold/gap timing, optional parity
// and slave-ready response windows.
// Accepts one word when in_valid && in_ready. It sequences setup, shift,
// hold and gap, then pulses out_done with the received word and error
// flag. Assumes configuration inputs are static while a word is in flight.
module spi_cst_master
    import spi_cst_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DATA_W = 8,
    parameter int TMR_W  = 4,
    parameter int WIN_W  = 3,
    parameter int DIV_W  = 3,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DIV_W-1:0]        sck_half,
    input  logic [NUM_CS*TMR_W-1:0] cfg_setup,
    input  logic [NUM_CS*TMR_W-1:0] cfg_hold,
    input  logic [NUM_CS*TMR_W-1:0] cfg_gap,
    input  logic [NUM_CS*WIN_W-1:0] cfg_en_on,
    input  logic [NUM_CS*WIN_W-1:0] cfg_en_off,
    input  logic [NUM_CS-1:0]       cfg_par_en,
    input  logic [NUM_CS-1:0]       cfg_par_even,
    input  logic [NUM_CS-1:0]       cfg_tmr_off,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [DATA_W-1:0]       in_data,
    input  logic [CS_W-1:0]         in_cs,
    input  logic                    in_hold_cs,
    output logic                    out_done,
    output logic                    out_err,
    output logic [DATA_W-1:0]       out_data,
    output logic                    sck,
    output logic                    mosi,
    input  logic                    miso,
    output logic [NUM_CS-1:0]       cs_n,
    input  logic                    slv_en_n
);
    localparam int LIM_W = WIN_W + DIV_W + 1;
    localparam int BIT_W = $clog2(DATA_W + 2);

    seq_state_t         state_q;
    logic [TMR_W-1:0]   cnt_q;
    logic [BIT_W-1:0]   bit_q;
    logic [DATA_W:0]    tx_q, rx_q;
    logic [CS_W-1:0]    cur_cs_q;
    logic               held_q, keep_q, err_acc_q, done_q, err_q;
    logic [DATA_W-1:0]  data_q;
    logic [NUM_CS-1:0]  cs_n_q;

    logic [TMR_W-1:0]   c_setup, c_hold, c_gap, su_eff, ho_eff;
    logic [WIN_W-1:0]   c_en_on, c_en_off;
    logic               c_par_en, c_par_even, c_tmr_off;
    logic [CS_W-1:0]    sel;
    logic [DIV_W-1:0]   half_eff;
    logic [LIM_W-1:0]   lim_on, lim_off;
    logic               accept, cont, run, rise, fall, last_bit;
    logic               on_start, off_start, on_exp, off_exp, on_res, off_res;
    logic               pbit;

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign cont     = held_q && (in_cs == cur_cs_q);
    assign sel      = in_ready ? in_cs : cur_cs_q;
    assign half_eff = (sck_half == '0) ? DIV_W'(1) : sck_half;
    assign su_eff   = c_tmr_off ? '0 : c_setup;
    assign ho_eff   = c_tmr_off ? '0 : c_hold;
    assign lim_on   = (LIM_W'(c_en_on) * LIM_W'(half_eff)) << 1;
    assign lim_off  = (LIM_W'(c_en_off) * LIM_W'(half_eff)) << 1;
    assign pbit     = c_par_even ? (^in_data) : ~(^in_data);
    assign last_bit = (bit_q == (c_par_en ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1)));
    assign run      = (state_q == ST_SHIFT);
    assign on_start = accept && !cont;
    assign off_start = run && fall && last_bit && !keep_q && !on_exp;

    spi_cst_cfgsel #(.NUM_CS(NUM_CS), .TMR_W(TMR_W), .WIN_W(WIN_W), .CS_W(CS_W)) u_cfg (
        .sel(sel), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_gap(cfg_gap),
        .cfg_en_on(cfg_en_on), .cfg_en_off(cfg_en_off), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_tmr_off(cfg_tmr_off),
        .setup(c_setup), .hold(c_hold), .gap(c_gap), .en_on(c_en_on), .en_off(c_en_off),
        .par_en(c_par_en), .par_even(c_par_even), .tmr_off(c_tmr_off));

    spi_cst_sckgen #(.DIV_W(DIV_W)) u_sck (
        .clk(clk), .rst_n(rst_n), .run(run), .half(half_eff),
        .sck(sck), .rise(rise), .fall(fall));

    spi_cst_window #(.CNT_W(LIM_W)) u_win_on (
        .clk(clk), .rst_n(rst_n), .start(on_start), .limit(lim_on),
        .level_ok(!slv_en_n), .expire(on_exp), .resolved(on_res));

    spi_cst_window #(.CNT_W(LIM_W)) u_win_off (
        .clk(clk), .rst_n(rst_n), .start(off_start), .limit(lim_off),
        .level_ok(slv_en_n), .expire(off_exp), .resolved(off_res));

    // Transfer sequencer, shift registers and chip select drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  cnt_q <= '0;  bit_q <= '0;
            tx_q <= '0;  rx_q <= '0;  cur_cs_q <= '0;
            held_q <= 1'b0;  keep_q <= 1'b0;  err_acc_q <= 1'b0;
            done_q <= 1'b0;  err_q <= 1'b0;  data_q <= '0;
            cs_n_q <= '1;
        end else begin
            done_q <= 1'b0;
            if (on_exp || off_exp) err_acc_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    cur_cs_q  <= in_cs;
                    tx_q      <= {in_data, pbit};
                    bit_q     <= '0;
                    keep_q    <= in_hold_cs;
                    held_q    <= 1'b0;
                    err_acc_q <= 1'b0;
                    err_q     <= 1'b0;
                    cs_n_q    <= ~(NUM_CS'(1) << in_cs);
                    if (cont || su_eff == '0) state_q <= ST_SHIFT;
                    else begin
                        state_q <= ST_SETUP;
                        cnt_q   <= su_eff;
                    end
                end
                ST_SETUP, ST_SHIFT: if (on_exp) begin
                    keep_q <= 1'b0;
                    if (ho_eff == '0) begin
                        cs_n_q <= '1;  state_q <= ST_GAP;  cnt_q <= c_gap;
                    end else begin
                        state_q <= ST_HOLD;  cnt_q <= ho_eff;
                    end
                end else if (state_q == ST_SETUP) begin
                    cnt_q <= cnt_q - TMR_W'(1);
                    if (cnt_q == TMR_W'(1)) state_q <= ST_SHIFT;
                end else if (rise) begin
                    rx_q <= {rx_q[DATA_W-1:0], miso};
                end else if (fall) begin
                    if (last_bit) begin
                        if (keep_q || ho_eff == '0) begin
                            if (!keep_q) cs_n_q <= '1;
                            state_q <= ST_GAP;  cnt_q <= c_gap;
                        end else begin
                            state_q <= ST_HOLD;  cnt_q <= ho_eff;
                        end
                    end else begin
                        bit_q <= bit_q + BIT_W'(1);
                        tx_q  <= {tx_q[DATA_W-1:0], 1'b0};
                    end
                end
                ST_HOLD: begin
                    cnt_q <= cnt_q - TMR_W'(1);
                    if (cnt_q == TMR_W'(1)) begin
                        cs_n_q  <= '1;  state_q <= ST_GAP;  cnt_q <= c_gap;
                    end
                end
                ST_GAP: if (cnt_q != '0) begin
                    cnt_q <= cnt_q - TMR_W'(1);
                end else if (on_res && off_res) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    err_q   <= err_acc_q || on_exp || off_exp;
                    held_q  <= keep_q;
                    data_q  <= c_par_en ? rx_q[DATA_W:1] : rx_q[DATA_W-1:0];
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign out_done = done_q;
    assign out_err  = err_q;
    assign out_data = data_q;
    assign cs_n     = cs_n_q;
    assign mosi     = tx_q[DATA_W];

    assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sck);
    assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sck && $past(sck) |-> $stable(mosi));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);
    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_err) |-> out_done);
endmodule

// File: tb/spi_cst_master_test.sv
// Self-checking bench: sweeps timing, parity and selection settings and the
// ready-window boundaries. Expected cycle counts come from the requirements.
module spi_cst_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 2;
    localparam int DW  = 8;
    localparam int TW  = 4;
    localparam int WW  = 3;
    localparam int DVW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DVW-1:0] sck_half = 3'd1;
    logic [NCS*TW-1:0] cfg_setup, cfg_hold, cfg_gap;
    logic [NCS*WW-1:0] cfg_en_on, cfg_en_off;
    logic [NCS-1:0] cfg_par_en, cfg_par_even, cfg_tmr_off;
    logic in_valid = 1'b0, in_hold_cs = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [0:0] in_cs = '0;
    logic in_ready, out_done, out_err, sck, mosi, miso;
    logic [DW-1:0] out_data;
    logic [NCS-1:0] cs_n;
    logic slv_en_n = 1'b1;

    int su_a[NCS], ho_a[NCS], gp_a[NCS], on_a[NCS], of_a[NCS];
    bit pe_a[NCS], pv_a[NCS], to_a[NCS];

    int total = 0, bad = 0, cyc = 0;
    int r_cslo, r_r1, r_f, r_csr, r_dn, r_nr, r_nf;
    bit r_other, r_err, r_pre;
    logic [8:0] r_bits;
    logic [DW-1:0] r_data;

    assign miso = mosi;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack the per-chip-select bench settings into the flat vectors.
    always_comb begin
        for (int i = 0; i < NCS; i++) begin
            cfg_setup[i*TW +: TW] = TW'(su_a[i]);
            cfg_hold[i*TW +: TW]  = TW'(ho_a[i]);
            cfg_gap[i*TW +: TW]   = TW'(gp_a[i]);
            cfg_en_on[i*WW +: WW] = WW'(on_a[i]);
            cfg_en_off[i*WW +: WW] = WW'(of_a[i]);
            cfg_par_en[i]   = pe_a[i];
            cfg_par_even[i] = pv_a[i];
            cfg_tmr_off[i]  = to_a[i];
        end
    end

    spi_cst_master #(.NUM_CS(NCS), .DATA_W(DW), .TMR_W(TW), .WIN_W(WW), .DIV_W(DVW)) uut (
        .clk(clk), .rst_n(rst_n), .sck_half(sck_half),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_gap(cfg_gap),
        .cfg_en_on(cfg_en_on), .cfg_en_off(cfg_en_off), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_tmr_off(cfg_tmr_off),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_cs(in_cs),
        .in_hold_cs(in_hold_cs), .out_done(out_done), .out_err(out_err),
        .out_data(out_data), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .slv_en_n(slv_en_n));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cs(input int c, input int su, input int ho, input int gp,
                          input int on, input int of, input bit pe, input bit pv,
                          input bit to);
        su_a[c] = su; ho_a[c] = ho; gp_a[c] = gp; on_a[c] = on; of_a[c] = of;
        pe_a[c] = pe; pv_a[c] = pv; to_a[c] = to;
    endtask

    // One word: drive the request, observe the serial side each negedge,
    // play the slave's ready line, stop at out_done.
    task automatic xfer(input int cs, input logic [DW-1:0] d, input bit hold,
                        input int d_on, input int d_off, input int nb);
        int t;
        bit prev;
        @(negedge clk);
        r_pre = cs_n[cs];
        in_valid = 1'b1; in_data = d; in_cs = 1'(cs); in_hold_cs = hold;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        r_cslo = -1; r_r1 = -1; r_f = -1; r_csr = -1; r_dn = -1;
        r_nr = 0; r_nf = 0; r_other = 0; r_bits = '0; prev = 1'b0;
        t = 0;
        while (t < 3000) begin
            if (!cs_n[cs] && r_cslo < 0) r_cslo = t;
            for (int j = 0; j < NCS; j++) if (j != cs && !cs_n[j]) r_other = 1;
            if (sck && !prev) begin
                if (r_r1 < 0) r_r1 = t;
                if (r_nr < 9) r_bits[8 - r_nr] = mosi;
                r_nr++;
            end
            if (!sck && prev) begin
                r_nf++;
                if (r_nf == nb) r_f = t;
            end
            if (r_cslo >= 0 && cs_n[cs] && r_csr < 0) r_csr = t;
            if (d_on >= 0 && t == d_on) slv_en_n = 1'b0;
            if (r_f >= 0 && d_off >= 0 && t - r_f == d_off) slv_en_n = 1'b1;
            prev = sck;
            if (out_done) begin
                r_dn = t; r_err = out_err; r_data = out_data;
                break;
            end
            @(negedge clk);
            t++;
        end
        if (!hold) slv_en_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCS; i++) set_cs(i, 0, 0, 0, 1, 1, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while in reset
        chk(cs_n == '1 && !sck && in_ready && !out_done, "R1", "in reset",
            {cs_n, sck, in_ready, out_done}, {2'b11, 1'b0, 1'b1, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == '1 && !sck && in_ready && !out_done, "R1", "after reset",
            {cs_n, sck, in_ready, out_done}, {2'b11, 1'b0, 1'b1, 1'b0});

        // Main sweep: R2 R3 R4 R5 R6 R10
        for (int h = 1; h <= 2; h++)
        for (int cs = 0; cs < NCS; cs++)
        for (int to = 0; to <= 1; to++)
        for (int su = 0; su <= 2; su++)
        for (int ho = 0; ho <= 2; ho++)
        for (int gp = 0; gp <= 1; gp++)
        for (int pm = 0; pm <= 2; pm++) begin
            int n, m, nb, e_r1, e_f, e_csr, e_dn;
            logic [DW-1:0] d;
            logic [8:0] e_bits;
            logic pb;
            sck_half = DVW'(h);
            set_cs(cs, su, ho, gp, 1, 1, pm != 0, pm == 2, 1'(to));
            set_cs(1 - cs, 3, 3, 2, 1, 1, pm == 0, pm != 2, 1'(1 - to));
            d = DW'((total * 37 + su * 11 + ho * 5 + pm) & 8'hFF);
            n = to ? 0 : su;
            m = to ? 0 : ho;
            nb = DW + (pm != 0);
            e_r1 = n + h;
            e_f = e_r1 + (2 * nb - 1) * h;
            e_csr = e_f + m;
            e_dn = e_csr + gp + 1;
            pb = (pm == 2) ? ^d : ~^d;
            e_bits = (pm != 0) ? {d, pb} : {d, 1'b0};
            xfer(cs, d, 1'b0, 0, 0, nb);
            chk(r_cslo == 0 && !r_other, "R10", "selected chip select only", r_cslo, 0);
            chk(r_r1 == e_r1, "R4", "cs low to first rise", r_r1, e_r1);
            chk(r_f == e_f && r_nr == nb, "R2", "last fall time", r_f, e_f);
            chk(r_bits == e_bits, (pm != 0) ? "R3" : "R2", "serial bits", r_bits, e_bits);
            chk(r_csr == e_csr, "R5", "last fall to cs rise", r_csr, e_csr);
            chk(r_dn == e_dn, "R6", "done time", r_dn, e_dn);
            chk(r_data == d && !r_err, "R2", "received word", r_data, d);
        end

        // R7: ready-assert window boundary
        for (int h = 1; h <= 2; h++)
        for (int e = 0; e <= 2; e++) begin
            int w;
            w = e * 2 * h;
            for (int dl = 0; dl <= w + 2; dl++) begin
                sck_half = DVW'(h);
                set_cs(0, 1, 1, 1, e, 1, 0, 0, 0);
                xfer(0, 8'hA5, 1'b0, dl, 0, DW);
                if (dl > w) begin
                    chk(r_err == 1'b1, "R7", "late ready flags error", r_err, 1);
                    chk(r_csr == w + 2, "R7", "cs release after abort", r_csr, w + 2);
                    chk(r_nr < DW, "R7", "shifting stops on abort", r_nr, DW - 1);
                    chk(r_dn == w + 4, "R7", "done after abort", r_dn, w + 4);
                end else begin
                    chk(r_err == 1'b0 && r_data == 8'hA5, "R7", "in-window ready", r_err, 0);
                end
            end
        end

        // R8: ready-release window boundary
        for (int h = 1; h <= 2; h++)
        for (int e = 0; e <= 2; e++) begin
            int w, e_f, e_dn;
            w = e * 2 * h;
            for (int dl = 0; dl <= w + 2; dl++) begin
                sck_half = DVW'(h);
                set_cs(1, 1, 1, 0, 1, e, 0, 0, 0);
                xfer(1, 8'h3C, 1'b0, 0, dl, DW);
                e_f = 1 + h + (2 * DW - 1) * h;
                e_dn = (dl > w) ? e_f + w + 1 : e_f + dl + 1;
                if (e_dn < e_f + 2) e_dn = e_f + 2;
                chk(r_err == (dl > w), "R8", "release window error", r_err, dl > w);
                chk(r_dn == e_dn, "R8", "done time with release window", r_dn, e_dn);
            end
        end

        // R9: held chip select across two words
        sck_half = 3'd1;
        set_cs(0, 2, 2, 1, 1, 1, 0, 0, 0);
        xfer(0, 8'h5A, 1'b1, 0, -1, DW);
        chk(r_csr == -1, "R9", "cs stays low after held word", r_csr, -1);
        chk(r_dn == 18 + 1 + 1, "R9", "held word skips hold", r_dn, 20);
        chk(r_err == 1'b0 && r_data == 8'h5A, "R9", "held word data", r_data, 8'h5A);
        xfer(0, 8'hC3, 1'b0, -1, 0, DW);
        chk(r_pre == 1'b0, "R9", "cs low between words", r_pre, 0);
        chk(r_r1 == 1, "R9", "continued word skips setup", r_r1, 1);
        chk(r_csr == 16 + 2, "R9", "final word applies hold", r_csr, 18);
        chk(r_err == 1'b0 && r_data == 8'hC3, "R9", "continued word data", r_data, 8'hC3);
        @(negedge clk);
        chk(cs_n == '1 && in_ready, "R9", "released after final word", cs_n, 3);

        // R11: done lasts one cycle and error clears on the next accept
        set_cs(0, 0, 0, 0, 0, 1, 0, 0, 0);
        xfer(0, 8'h0F, 1'b0, 5, 0, DW);
        chk(r_err == 1'b1, "R11", "error reported with done", r_err, 1);
        @(negedge clk);
        chk(!out_done && out_err, "R11", "done one cycle, error held", out_done, 0);
        in_valid = 1'b1; in_data = 8'h00; in_cs = 1'b0; in_hold_cs = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(!out_err, "R11", "error cleared on accept", out_err, 0);
        slv_en_n = 1'b0;
        while (!out_done) @(negedge clk);
        slv_en_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule